// File: doc/BRIEF.md
# Dual Capture/Compare Timer Channel

This block is one channel of a 16-bit timer. A free-running up-counter advances on each count-clock enable while the channel runs. Two 16-bit registers sit beside it. Each register acts either as a compare register, which pulses a match output when the counter reaches its value, or as a capture register, which stores the counter value when a trigger edge arrives and raises a one-cycle capture flag.

Two timer inputs drive the triggers. Each passes through a two-flop synchronizer and a noise filter, both stepped by the count-clock enable. Each input has its own edge-select field. A three-bit control register sets the mode of each register and picks the trigger of the first register. That trigger is either the valid edge of the second input or the edge of the first input opposite to its configured valid edge. The control register can only be changed while the counter is stopped. An optional clear-on-match mode restarts the counter when it matches the first register.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset the control value, counter, both registers, match outputs, capture flags and the error bit are all zero.
- R2: While `run` is high the counter rises by one on every cycle with `cnt_en` high and holds on other cycles. While `run` is low the counter is held at zero.
- R3: A register in compare mode gives a one-cycle match pulse on the cycle after a counted cycle in which the counter equals its value. The counter has already advanced when the pulse is seen.
- R4: Control bit 0 sets register 0 to capture (1) or compare (0). Bit 2 does the same for register 1. Bit 1 picks the trigger of register 0. `ctl_q` bits 7..3 read zero. A control write is taken only while `run` is low. A write while running leaves the value unchanged and sets the sticky `ctl_err`.
- R5: Edge-select codes are 00 none, 01 falling, 10 rising, 11 both. Register 1 in capture mode captures on the valid edge of input 0 and ignores the other edge.
- R6: With bit 1 = 0, register 0 in capture mode captures on the valid edge of input 1. The stored value is the count of the cycle before the flag, and the flag lasts one cycle.
- R7: With bit 1 = 1, register 0 captures on the edge of input 0 opposite to its select: falling when the select is rising, rising when it is falling.
- R8: With bit 1 = 1 and input 0 set to both edges, register 0 never captures.
- R9: An input level counts only after three consecutive equal samples. A pulse lasting two enabled samples gives no capture, and one lasting three does.
- R10: With `clr_on_match` high, the counter goes to zero on the count after it equals register 0. Register 0 stays in compare mode even if bit 0 asks for capture.
- R11: When a capture and a software write reach the same register in the same cycle, the captured value is stored. A write with no capture loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable, also steps the input filters |
| run | input | 1 | Counter running when high, held at zero when low |
| clr_on_match | input | 1 | Restart counter after a match with register 0 |
| ti0_edge | input | 2 | Edge select for input 0 |
| ti1_edge | input | 2 | Edge select for input 1 |
| ti0_in | input | 1 | Timer input 0 |
| ti1_in | input | 1 | Timer input 1 |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data (bits 2..0) |
| cr0_we | input | 1 | Register 0 write strobe |
| cr1_we | input | 1 | Register 1 write strobe |
| cr_wdata | input | 16 | Register write data |
| ctl_q | output | 8 | Control register read value |
| ctl_err | output | 1 | Sticky flag for a control write while running |
| cnt_q | output | 16 | Counter value |
| cr0_q | output | 16 | Register 0 value |
| cr1_q | output | 16 | Register 1 value |
| match0 | output | 1 | Register 0 compare match pulse |
| match1 | output | 1 | Register 1 compare match pulse |
| cap0 | output | 1 | Register 0 capture flag |
| cap1 | output | 1 | Register 1 capture flag |

## Verification
Captures are tried with a rising edge on input 1 and then its falling edge, which separates a correct edge decoder from one that fires on any change. Input 0 is driven with both edge polarities under the direct and the reverse-phase trigger and under the both-edges select, so a swapped opposite-edge mapping or a missing suppression shows up as a capture or as a missing one. Pulses of two and three enabled samples bracket the filter threshold. A write timed to land on the capture cycle checks the priority rule. Compare matches are checked both with a free-running counter and with clear-on-match active.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int CTL_CAP0 = 0;
  localparam int CTL_REV0 = 1;
  localparam int CTL_CAP1 = 2;

  function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
    case (sel)
      EDGE_FALL: edge_hit = fall;
      EDGE_RISE: edge_hit = rise;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  function automatic logic edge_opposite(edge_sel_e sel, logic rise, logic fall);
    case (sel)
      EDGE_FALL: edge_opposite = rise;
      EDGE_RISE: edge_opposite = fall;
      default:   edge_opposite = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_in_filter.sv
module tmr_in_filter #(
  parameter int STABLE_N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int HW = STABLE_N - 1;

  logic [1:0]    sync;
  logic [HW-1:0] hist;
  logic          filt, filt_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync   <= '0;
      hist   <= '0;
      filt   <= 1'b0;
      filt_d <= 1'b0;
    end else begin
      filt_d <= filt;
      if (tick) begin
        sync <= {sync[0], pin};
        hist <= (hist << 1) | HW'(sync[1]);
        if (hist == {HW{sync[1]}}) filt <= sync[1];
      end
    end
  end

  assign rise = filt & ~filt_d;
  assign fall = ~filt & filt_d;

  assert_filt_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt) |-> $past(tick));
endmodule

// File: rtl/tmr_cc_reg.sv
module tmr_cc_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic         cap_mode,
  input  logic         trig,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] val,
  output logic         match,
  output logic         cap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val   <= '0;
      match <= 1'b0;
      cap   <= 1'b0;
    end else begin
      match <= run && tick && !cap_mode && (cnt == val);
      cap   <= 1'b0;
      if (run && cap_mode && trig) begin
        val <= cnt;
        cap <= 1'b1;
      end else if (we) begin
        val <= wdata;
      end
    end
  end

  assert_no_cap_and_match_R3: assert property (@(posedge clk) disable iff (rst)
    !(cap && match));
  assert_cap_value_R6: assert property (@(posedge clk) disable iff (rst)
    cap |-> (val == $past(cnt)));
endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
  import tmr_cc_pkg::*;
#(
  parameter int W        = 16,
  parameter int STABLE_N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         run,
  input  logic         clr_on_match,
  input  logic [1:0]   ti0_edge,
  input  logic [1:0]   ti1_edge,
  input  logic         ti0_in,
  input  logic         ti1_in,
  input  logic         ctl_we,
  input  logic [2:0]   ctl_wdata,
  input  logic         cr0_we,
  input  logic         cr1_we,
  input  logic [W-1:0] cr_wdata,
  output logic [7:0]   ctl_q,
  output logic         ctl_err,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cr0_q,
  output logic [W-1:0] cr1_q,
  output logic         match0,
  output logic         match1,
  output logic         cap0,
  output logic         cap1
);
  localparam int NCH = 2;

  logic [2:0]     ctl;
  logic [W-1:0]   cnt;
  logic [NCH-1:0] pin, rise, fall;
  logic [NCH-1:0] cap_mode, trig, we, match, cap;
  logic [W-1:0]   val [NCH];
  logic           ti0_valid, ti1_valid, ti0_opp;

  assign pin = {ti1_in, ti0_in};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_filt
      tmr_in_filter #(.STABLE_N(STABLE_N)) u_filt (
        .clk(clk), .rst(rst), .tick(cnt_en), .pin(pin[i]),
        .rise(rise[i]), .fall(fall[i]));
    end
  endgenerate

  always_comb begin
    ti0_valid   = edge_hit(edge_sel_e'(ti0_edge), rise[0], fall[0]);
    ti1_valid   = edge_hit(edge_sel_e'(ti1_edge), rise[1], fall[1]);
    ti0_opp     = edge_opposite(edge_sel_e'(ti0_edge), rise[0], fall[0]);
    cap_mode[0] = ctl[CTL_CAP0] & ~clr_on_match;
    cap_mode[1] = ctl[CTL_CAP1];
    trig[0]     = ctl[CTL_REV0] ? ti0_opp : ti1_valid;
    trig[1]     = ti0_valid;
    we          = {cr1_we, cr0_we};
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_reg
      tmr_cc_reg #(.W(W)) u_reg (
        .clk(clk), .rst(rst), .tick(cnt_en), .run(run),
        .cap_mode(cap_mode[i]), .trig(trig[i]), .we(we[i]),
        .wdata(cr_wdata), .cnt(cnt), .val(val[i]),
        .match(match[i]), .cap(cap[i]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt_en) begin
      if (clr_on_match && (cnt == val[0])) cnt <= '0;
      else                                 cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      ctl_err <= 1'b0;
    end else if (ctl_we) begin
      if (run) ctl_err <= 1'b1;
      else     ctl     <= ctl_wdata;
    end
  end

  assign ctl_q  = {5'b0, ctl};
  assign cnt_q  = cnt;
  assign cr0_q  = val[0];
  assign cr1_q  = val[1];
  assign match0 = match[0];
  assign match1 = match[1];
  assign cap0   = cap[0];
  assign cap1   = cap[1];

  assert_ctl_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (run && ctl_we) |=> ($stable(ctl_q) && ctl_err));
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    ctl_err |=> ctl_err);
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
  assert_rev_both_R8: assert property (@(posedge clk) disable iff (rst)
    cap0 |-> !$past(ctl[CTL_REV0] && (ti0_edge == 2'b11)));
  assert_clr_forces_cmp_R10: assert property (@(posedge clk) disable iff (rst)
    cap0 |-> !$past(clr_on_match));
endmodule

// File: tb/tmr_cc_channel_bench.sv
`timescale 1ns/1ps
module tmr_cc_channel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b1, run = 1'b0, clr_on_match = 1'b0;
  logic [1:0]  ti0_edge = 2'b00, ti1_edge = 2'b00;
  logic        ti0_in = 1'b0, ti1_in = 1'b0;
  logic        ctl_we = 1'b0, cr0_we = 1'b0, cr1_we = 1'b0;
  logic [2:0]  ctl_wdata = '0;
  logic [15:0] cr_wdata = '0;
  logic [7:0]  ctl_q;
  logic        ctl_err;
  logic [15:0] cnt_q, cr0_q, cr1_q;
  logic        match0, match1, cap0, cap1;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  tmr_cc_channel u_tmr_cc_channel (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .run(run), .clr_on_match(clr_on_match),
    .ti0_edge(ti0_edge), .ti1_edge(ti1_edge), .ti0_in(ti0_in), .ti1_in(ti1_in),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .cr0_we(cr0_we), .cr1_we(cr1_we),
    .cr_wdata(cr_wdata), .ctl_q(ctl_q), .ctl_err(ctl_err), .cnt_q(cnt_q),
    .cr0_q(cr0_q), .cr1_q(cr1_q), .match0(match0), .match1(match1),
    .cap0(cap0), .cap1(cap1));

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [2:0] v);
    run = 1'b0; ctl_we = 1'b1; ctl_wdata = v;
    step();
    ctl_we = 1'b0;
  endtask

  // waits up to lim cycles for cap0 (which=0) or cap1 (which=1)
  task automatic wait_cap(input int which, input int lim, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < lim && !seen; k++) begin
      step();
      if ((which == 0 && cap0) || (which == 1 && cap1)) seen = 1'b1;
    end
  endtask

  task automatic t_reset;
    chk(ctl_q == 8'h00 && ctl_err == 1'b0, "R1 ctl", ctl_q, 0);
    chk(cnt_q == 0 && cr0_q == 0 && cr1_q == 0, "R1 regs", cnt_q + cr0_q + cr1_q, 0);
    chk(!match0 && !match1 && !cap0 && !cap1, "R1 flags",
        int'(match0) + int'(match1) + int'(cap0) + int'(cap1), 0);
  endtask

  task automatic t_count;
    run = 1'b1; step(5);
    chk(cnt_q == 5, "R2 count", cnt_q, 5);
    cnt_en = 1'b0; step(4);
    chk(cnt_q == 5, "R2 hold without enable", cnt_q, 5);
    cnt_en = 1'b1; step(2);
    chk(cnt_q == 7, "R2 resume", cnt_q, 7);
    run = 1'b0; step();
    chk(cnt_q == 0, "R2 stopped at zero", cnt_q, 0);
  endtask

  task automatic t_ctl_write;
    set_ctl(3'b111);
    chk(ctl_q == 8'h07, "R4 write stopped", ctl_q, 7);
    run = 1'b1; ctl_we = 1'b1; ctl_wdata = 3'b000; step();
    ctl_we = 1'b0;
    chk(ctl_q == 8'h07, "R4 write while running ignored", ctl_q, 7);
    chk(ctl_err == 1'b1, "R4 error set", ctl_err, 1);
    step(3);
    chk(ctl_err == 1'b1, "R4 error sticky", ctl_err, 1);
    set_ctl(3'b000);
  endtask

  task automatic t_match;
    bit m0, m1;
    set_ctl(3'b000);
    cr_wdata = 16'd20; cr0_we = 1'b1; step(); cr0_we = 1'b0;
    cr_wdata = 16'd30; cr1_we = 1'b1; step(); cr1_we = 1'b0;
    run = 1'b1; m0 = 0; m1 = 0;
    for (int k = 0; k < 60 && !m1; k++) begin
      step();
      if (match0) begin
        m0 = 1;
        chk(cnt_q == 21, "R3 match0 timing", cnt_q, 21);
        step();
        chk(!match0, "R3 match0 one cycle", match0, 0);
      end
      if (match1) begin
        m1 = 1;
        chk(cnt_q == 31, "R3 match1 timing", cnt_q, 31);
      end
    end
    chk(m0 && m1, "R3 both matches seen", int'(m0) + int'(m1), 2);
    run = 1'b0; step();
  endtask

  task automatic t_cap_ti1;
    bit seen;
    set_ctl(3'b001); ti1_edge = 2'b10; run = 1'b1; step(10);
    ti1_in = 1'b1;
    wait_cap(0, 12, seen);
    chk(seen, "R6 capture on rising input 1", seen, 1);
    chk(cr0_q == cnt_q - 16'd1, "R6 captured value", cr0_q, cnt_q - 16'd1);
    step();
    chk(!cap0, "R6 flag one cycle", cap0, 0);
    ti1_in = 1'b0;
    wait_cap(0, 12, seen);
    chk(!seen, "R5 falling ignored by rising select", seen, 0);
    run = 1'b0; step();
  endtask

  task automatic t_cap_cr1;
    bit seen;
    set_ctl(3'b100); ti0_edge = 2'b01; run = 1'b1; step(8);
    ti0_in = 1'b1;
    wait_cap(1, 12, seen);
    chk(!seen, "R5 cr1 ignores rising with falling select", seen, 0);
    ti0_in = 1'b0;
    wait_cap(1, 12, seen);
    chk(seen, "R5 cr1 captures falling", seen, 1);
    chk(cr1_q == cnt_q - 16'd1, "R5 cr1 captured value", cr1_q, cnt_q - 16'd1);
    run = 1'b0; step();
  endtask

  task automatic t_reverse;
    bit seen;
    set_ctl(3'b011); ti0_edge = 2'b10; run = 1'b1; step(8);
    ti0_in = 1'b1;
    wait_cap(0, 12, seen);
    chk(!seen, "R7 no capture on configured rising edge", seen, 0);
    ti0_in = 1'b0;
    wait_cap(0, 12, seen);
    chk(seen, "R7 capture on opposite falling edge", seen, 1);
    chk(cr0_q == cnt_q - 16'd1, "R7 captured value", cr0_q, cnt_q - 16'd1);
    ti0_edge = 2'b01; step(4);
    ti0_in = 1'b1;
    wait_cap(0, 12, seen);
    chk(seen, "R7 capture on opposite rising edge", seen, 1);
    ti0_in = 1'b0; step(12);
    run = 1'b0; step();
  endtask

  task automatic t_rev_both;
    bit s1, s2;
    set_ctl(3'b011); ti0_edge = 2'b11; run = 1'b1; step(8);
    ti0_in = 1'b1; wait_cap(0, 12, s1);
    ti0_in = 1'b0; wait_cap(0, 12, s2);
    chk(!s1 && !s2, "R8 both-edge select suppresses capture", int'(s1) + int'(s2), 0);
    run = 1'b0; step();
  endtask

  task automatic t_filter;
    bit seen;
    set_ctl(3'b001); ti1_edge = 2'b10; run = 1'b1; step(8);
    ti1_in = 1'b1; step(2); ti1_in = 1'b0;
    wait_cap(0, 15, seen);
    chk(!seen, "R9 two-sample pulse rejected", seen, 0);
    ti1_in = 1'b1; step(3); ti1_in = 1'b0;
    wait_cap(0, 15, seen);
    chk(seen, "R9 three-sample pulse accepted", seen, 1);
    step(10);
    run = 1'b0; step();
  endtask

  task automatic t_clear;
    bit seen;
    set_ctl(3'b001); ti1_edge = 2'b10; clr_on_match = 1'b1;
    cr_wdata = 16'd10; cr0_we = 1'b1; step(); cr0_we = 1'b0;
    run = 1'b1; seen = 0;
    for (int k = 0; k < 30 && !seen; k++) begin
      step();
      if (match0) seen = 1;
    end
    chk(seen && cnt_q == 0, "R10 counter cleared on match", cnt_q, 0);
    step(11);
    chk(match0 && cnt_q == 0, "R10 period of eleven counts", cnt_q, 0);
    ti1_in = 1'b1;
    wait_cap(0, 12, seen);
    chk(!seen && cr0_q == 16'd10, "R10 cr0 kept in compare mode", cr0_q, 10);
    ti1_in = 1'b0; step(8);
    clr_on_match = 1'b0; run = 1'b0; step();
  endtask

  task automatic t_priority;
    set_ctl(3'b001); ti1_edge = 2'b10; run = 1'b1; step(8);
    ti1_in = 1'b1; step(5);
    cr_wdata = 16'hBEEF; cr0_we = 1'b1; step(); cr0_we = 1'b0;
    chk(cap0, "R11 capture in write cycle", cap0, 1);
    chk(cr0_q == cnt_q - 16'd1, "R11 capture wins over write", cr0_q, cnt_q - 16'd1);
    cr_wdata = 16'h1234; cr0_we = 1'b1; step(); cr0_we = 1'b0;
    chk(cr0_q == 16'h1234, "R11 plain write loads", cr0_q, 16'h1234);
    ti1_in = 1'b0; run = 1'b0; step();
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step();
    t_reset();
    t_count();
    t_match();
    t_cap_ti1();
    t_cap_cr1();
    t_reverse();
    t_rev_both();
    t_filter();
    t_clear();
    t_priority();
    t_ctl_write();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule